// File: doc/BRIEF.md
# Transceiver-Clocked Packet Serializer

This block sends one fixed-layout radio packet, one bit at a time, to a transceiver that generates its own bit clock. The host presents a 32-bit measurement word and pulses a start input. The block then computes a 16-bit CRC over that word and asserts the transceiver select. It sends the frame one bit per rising edge of the transceiver's data clock, in this order: an alternating training pattern, then a 24-bit sync word, then the payload, then the CRC.

The data clock comes from another clock domain. It passes through a two-flop synchronizer into the system clock domain, and the block detects rising edges on the synchronized copy. The output bit is updated only in the system clock cycle that follows a detected rising edge. It therefore holds steady for the whole period of the transceiver clock, however long that period lasts. The rising edge that follows the last bit ends the packet: the select drops and a one-cycle done pulse is issued.

Top module: `radio_pkt_ser`

## Requirements
- R1: While reset is asserted and right after it, sel_o, busy_o, data_o and done_o are all 0.
- R2: A start_i pulse while busy_o is 0 latches payload_i and sets sel_o and busy_o to 1 on the next clock edge.
- R3: The first 64 frame bits are eight 0xAA bytes, sent MSB first (1,0,1,0,...).
- R4: The next 24 bits are the SYNC_WORD parameter, sent MSB first.
- R5: The next 32 bits are the latched payload, sent MSB first.
- R6: The last 16 bits are CRC-16 over the payload bytes (payload[31:24] first), sent MSB first. The CRC uses polynomial 0x1021, initial value 0xFFFF, no bit reflection and no final XOR.
- R7: data_o changes only in the cycle right after a synchronized rising edge of dclk_i. While dclk_i stays low, data_o holds its value.
- R8: The rising edge after the last frame bit clears sel_o and busy_o, returns data_o to 0, and pulses done_o high for exactly one cycle, once per frame.
- R9: A start_i pulse while busy_o is 1 is ignored. The frame in flight keeps its payload and its length.
- R10: Rising edges on dclk_i while idle change nothing: data_o and sel_o stay 0 and done_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to send one packet |
| payload_i | input | 32 | Measurement word, sampled at an accepted start |
| dclk_i | input | 1 | Bit clock from the transceiver (asynchronous) |
| sel_o | output | 1 | Transceiver select, high for the whole packet |
| data_o | output | 1 | Serial bit to the transceiver |
| busy_o | output | 1 | A packet is in progress |
| done_o | output | 1 | One-cycle pulse when the packet ends |

## Verification
The bench uses the default eight-byte preamble and a sync word of 0x5AC396. That word does not follow the alternating training pattern, so a boundary that is off by one bit shows up as a field mismatch. The bench varies the data clock's low time from a few system cycles up to many cycles. This exercises the synchronizer latency and a long hold of a single bit. The payloads it sends include all-zeros, all-ones and a mixed word, so the CRC is checked against an independent byte-wise model from its initial state through heavy feedback.

// File: rtl/radio_pkt_ser_pkg.sv
package radio_pkt_ser_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } ser_state_e;

  localparam int unsigned CRC_W    = 16;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;
  localparam logic [7:0]  PRE_BYTE = 8'hAA;
endpackage

// File: rtl/dclk_edge_sync.sv
module dclk_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dclk_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], dclk_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/crc16_calc.sv
module crc16_calc
  import radio_pkt_ser_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  // bitwise MSB-first, no reflection, no final xor
  always_comb begin
    logic [CRC_W-1:0] c;
    logic             fb;
    c = CRC_INIT;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ data_i[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    crc_o = c;
  end
endmodule

// File: rtl/frame_builder.sv
module frame_builder
  import radio_pkt_ser_pkg::*;
#(
  parameter int unsigned   PRE_BYTES = 8,
  parameter int unsigned   SYNC_W    = 24,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 24'h5AC396,
  parameter int unsigned   PAY_W     = 32,
  localparam int unsigned  PRE_W     = PRE_BYTES * 8,
  localparam int unsigned  FRAME_W   = PRE_W + SYNC_W + PAY_W + CRC_W
) (
  input  logic [PAY_W-1:0]   payload_i,
  input  logic [CRC_W-1:0]   crc_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [PRE_W-1:0] pre;

  for (genvar g = 0; g < PRE_BYTES; g++) begin : g_pre
    assign pre[g*8 +: 8] = PRE_BYTE;
  end

  assign frame_o = {pre, SYNC_WORD, payload_i, crc_i};
endmodule

// File: rtl/bit_shifter.sv
module bit_shifter
  import radio_pkt_ser_pkg::*;
#(
  parameter int unsigned  FRAME_W = 136,
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               rise_i,
  output logic               sel_o,
  output logic               data_o,
  output logic               busy_o,
  output logic               done_o
);
  ser_state_e         state_q;
  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      cnt_q   <= '0;
      sel_o   <= 1'b0;
      data_o  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            shreg_q <= frame_i;
            cnt_q   <= '0;
            sel_o   <= 1'b1;
            state_q <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (rise_i) begin
            if (cnt_q == CNT_W'(FRAME_W)) begin
              // edge after last bit closes the packet
              state_q <= ST_IDLE;
              sel_o   <= 1'b0;
              data_o  <= 1'b0;
              done_o  <= 1'b1;
            end else begin
              data_o  <= shreg_q[FRAME_W-1];
              shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
              cnt_q   <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == ST_SEND);
endmodule

// File: rtl/radio_pkt_ser.sv
module radio_pkt_ser
  import radio_pkt_ser_pkg::*;
#(
  parameter int unsigned       PRE_BYTES   = 8,
  parameter int unsigned       SYNC_W      = 24,
  parameter logic [SYNC_W-1:0] SYNC_WORD   = 24'h5AC396,
  parameter int unsigned       SYNC_STAGES = 2,
  localparam int unsigned      PAY_W       = 32,
  localparam int unsigned      FRAME_W     = PRE_BYTES * 8 + SYNC_W + PAY_W + CRC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PAY_W-1:0] payload_i,
  input  logic             dclk_i,
  output logic             sel_o,
  output logic             data_o,
  output logic             busy_o,
  output logic             done_o
);
  logic               dclk_rise;
  logic [CRC_W-1:0]   crc;
  logic [FRAME_W-1:0] frame;

  dclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dclk_i (dclk_i),
    .rise_o (dclk_rise)
  );

  crc16_calc #(.DATA_W(PAY_W)) u_crc (
    .data_i (payload_i),
    .crc_o  (crc)
  );

  frame_builder #(
    .PRE_BYTES (PRE_BYTES),
    .SYNC_W    (SYNC_W),
    .SYNC_WORD (SYNC_WORD),
    .PAY_W     (PAY_W)
  ) u_frame (
    .payload_i (payload_i),
    .crc_i     (crc),
    .frame_o   (frame)
  );

  bit_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .frame_i (frame),
    .rise_i  (dclk_rise),
    .sel_o   (sel_o),
    .data_o  (data_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );
endmodule

// File: rtl/radio_pkt_ser_chk.sv
module radio_pkt_ser_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic dclk_rise_i,
  input logic sel_o,
  input logic data_o,
  input logic busy_o,
  input logic done_o
);
  a_r2_start_selects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (sel_o && busy_o));

  a_r7_data_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_o != $past(data_o)) |-> $past(dclk_rise_i));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!sel_o && !busy_o));

  a_r8_end_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r9_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !dclk_rise_i) |=> busy_o);

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_o |-> !data_o);
endmodule

bind radio_pkt_ser radio_pkt_ser_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .dclk_rise_i (dclk_rise),
  .sel_o       (sel_o),
  .data_o      (data_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/tb_radio_pkt_ser.sv
module tb_radio_pkt_ser;
  localparam logic [23:0] SYNC    = 24'h5AC396;
  localparam int          FRAME_W = 64 + 24 + 32 + 16;
  localparam int          NVEC    = 4;
  // payload, dclk low time, mode (0 plain, 1 mid-frame start, 2 long hold)
  localparam logic [31:0] VPAY  [NVEC] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h41C8_3D71, 32'h1234_5678};
  localparam int          VLOW  [NVEC] = '{3, 5, 4, 9};
  localparam int          VMODE [NVEC] = '{0, 1, 2, 0};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dclk = 1'b0;
  logic [31:0] payload = '0;
  logic sel, data, busy, done;
  int total = 0, bad = 0, done_cnt = 0;

  always #5 clk = ~clk;
  always @(posedge clk) if (done) done_cnt <= done_cnt + 1;

  radio_pkt_ser #(.SYNC_WORD(SYNC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .payload_i(payload),
    .dclk_i(dclk), .sel_o(sel), .data_o(data), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [31:0] p);
    logic [15:0] c = 16'hFFFF;
    for (int b = 3; b >= 0; b--) begin
      c = c ^ {p[b*8 +: 8], 8'h00};
      for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic dpulse(input int low);
    dclk = 1'b1;
    tick(4);
    dclk = 1'b0;
    tick(low);
  endtask

  task automatic send(input logic [31:0] p, input int low, input int mode);
    logic [FRAME_W-1:0] fr = '0;
    logic [63:0] pre_exp = {8{8'hAA}};
    int d0 = done_cnt;
    logic hold;
    bit stable;
    payload = p;
    start = 1'b1;
    tick(1);
    start = 1'b0;
    payload = ~p;
    chk(sel && busy, "R2 select after start", {sel, busy}, 2'b11);
    for (int i = 0; i < FRAME_W; i++) begin
      dclk = 1'b1;
      tick(4);
      fr = {fr[FRAME_W-2:0], data};
      dclk = 1'b0;
      if (mode == 1 && i == 40) begin
        start = 1'b1;
        tick(1);
        start = 1'b0;
        tick(low);
      end else if (mode == 2 && i == 100) begin
        hold = data;
        stable = 1'b1;
        for (int k = 0; k < 60; k++) begin
          tick(1);
          if (data !== hold) stable = 1'b0;
        end
        chk(stable, "R7 bit held while dclk low", {63'b0, data}, {63'b0, hold});
      end else tick(low);
    end
    chk(fr[FRAME_W-1 -: 64] == pre_exp, "R3 preamble", fr[FRAME_W-1 -: 64], pre_exp);
    chk(fr[FRAME_W-65 -: 24] == SYNC, "R4 sync word", 64'(fr[FRAME_W-65 -: 24]), 64'(SYNC));
    chk(fr[FRAME_W-89 -: 32] == p, mode == 1 ? "R9 payload kept after busy start" : "R5 payload",
        64'(fr[FRAME_W-89 -: 32]), 64'(p));
    chk(fr[15:0] == ref_crc(p), "R6 crc", 64'(fr[15:0]), 64'(ref_crc(p)));
    chk(sel && busy && done_cnt == d0, "R8 still busy before closing edge", {sel, busy}, 2'b11);
    dpulse(low);
    chk(!sel && !busy && !data, "R8 released", {sel, busy, data}, 3'b000);
    chk(done_cnt == d0 + 1, "R8 one done pulse", 64'(done_cnt - d0), 64'd1);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
    tick(3);
    chk(!sel && !busy && !data && !done, "R1 in reset", {sel, busy, data, done}, 4'b0);
    rst_n = 1'b1;
    tick(2);
    chk(!sel && !busy && !data && !done, "R1 after reset", {sel, busy, data, done}, 4'b0);
    // R10: idle edges do nothing
    for (int i = 0; i < 5; i++) dpulse(3);
    chk(!sel && !data && done_cnt == 0, "R10 idle dclk", {sel, data}, 2'b00);
    for (int v = 0; v < NVEC; v++) send(VPAY[v], VLOW[v], VMODE[v]);
    for (int i = 0; i < 3; i++) dpulse(2);
    chk(!sel && !data && done_cnt == NVEC, "R10 idle dclk after frames", 64'(done_cnt), 64'(NVEC));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule